// File: doc/BRIEF.md
# Touch Key Arbiter and Output Encoder

This block sits behind the per-key touch qualification logic of a capacitive keypad controller. On every clock it takes a candidate-touch flag, a signal-strength delta and an enable bit for each key. It then decides which keys are reported as active. Adjacent key suppression can be switched off, applied within two fixed groups of four keys, or applied across all keys. When it is on, only the strongest candidate in each group survives. The active set is registered. The decision for the next cycle gives the incumbent key the advantage on a tie in strength.

The registered set drives the key outputs in one of four formats. Three formats are direct, with one line per key. The fourth is a binary code that holds the key touched first until that key lets go. A detect line gives the OR of all active keys. Each output is modelled as a data bit plus an output enable, so push-pull and open-drain drive are both expressed without pads. A fast-detect grant is also produced. It passes a fast-detect request through only while suppression is off.

Top module: `touch_key_arbiter`

## Requirements
- R1: While the reset `rstN` is low, no key is active and the hold state is cleared. Format `01` then shows all key lines and the detect line at 0. Format `00` shows them all at 1, with every enable at 1.
- R2: With `aksMode` `10` or `11` (global), at most one key is active. It is the enabled candidate with the largest delta among all keys.
- R3: With `aksMode` `01` (grouped), keys 0, 1, 4, 5 form one group and keys 2, 3, 6, 7 form the other. Each group independently keeps only its strongest enabled candidate, so up to two keys can be active.
- R4: A key whose `keyEnable` bit is 0 is never active and takes no part in suppression. With `aksMode` `00`, the active set equals `candFlags & keyEnable`.
- R5: When the largest delta in a group is shared, a tied key that was active in the previous cycle wins. Otherwise the lowest-numbered tied key wins.
- R6: In binary format, the code shows the first key to become active. It holds that key while the key stays active, and keys that become active later stay hidden.
- R7: When the held key goes inactive, the code moves to the lowest-numbered key still active. If several keys become active in the same cycle from none, the lowest-numbered one is taken. With no key active, the code is 000.
- R8: The detect line is the OR of the active keys. In binary format, code 000 means key 0 only while detect is 1.
- R9: Output formats are: `00` direct active-low push-pull; `01` direct active-high push-pull; `10` direct active-low open-drain, where data is 0 and the enable is 1 only for active lines; `11` binary active-high push-pull, with the code on `outData[2:0]`, the other lines at 0 and all enables at 1. Detect follows the polarity and drive of the selected format.
- R10: `fastGrant` is 1 only when `fastReq` is 1 and `aksMode` is `00`.
- R11: Inputs sampled at a rising clock edge are reflected on the outputs after that edge. The next suppression decision uses the registered active set as the incumbent set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| candFlags | input | 8 | Per-key candidate touch flags |
| keyEnable | input | 8 | Per-key enable mask |
| keyDelta | input | 64 | Per-key signal delta, key k in bits [8k+7:8k] |
| aksMode | input | 2 | 00 off, 01 grouped, 10/11 global |
| outFormat | input | 2 | Output format select (see R9) |
| fastReq | input | 1 | Fast-detect request |
| outData | output | 8 | Key output data bits |
| outOe | output | 8 | Key output enables |
| detData | output | 1 | Detect data bit |
| detOe | output | 1 | Detect output enable |
| fastGrant | output | 1 | Fast-detect granted |

## Verification
The bench sweeps every candidate pattern under each suppression mode, with both a full and a partial enable mask. The deltas are drawn from a narrow range, so ties occur often and the incumbent rule is exercised. This separates per-group winners from global winners and shows whether disabled keys leak into the comparison. Directed sequences follow the binary code through overlapping presses and releases, which checks the hold rule and the rule for which waiting key is shown next. A sequence of equal deltas isolates the tie priority. Each output format is then driven with the same active set, so that polarity and drive mistakes show up at the data and enable pins.

// File: rtl/tka_pkg.sv
package tka_pkg;
  typedef enum logic [1:0] {
    AKS_OFF     = 2'b00,
    AKS_PAIRS   = 2'b01,
    AKS_ALL     = 2'b10,
    AKS_ALL_ALT = 2'b11
  } aks_mode_e;

  typedef enum logic [1:0] {
    FMT_LOW_PP  = 2'b00,
    FMT_HIGH_PP = 2'b01,
    FMT_LOW_OD  = 2'b10,
    FMT_BIN     = 2'b11
  } out_fmt_e;

  typedef struct packed {
    logic binMode;
    logic actLow;
    logic openDrain;
  } drive_ctrl_t;
endpackage

// File: rtl/tka_datapath.sv
module tka_datapath
  import tka_pkg::*;
#(
  parameter int NumKeys = 8,
  parameter int DeltaW  = 8,
  parameter int CodeW   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumKeys-1:0]        candFlags,
  input  logic [NumKeys-1:0]        keyEnable,
  input  logic [NumKeys*DeltaW-1:0] keyDelta,
  input  logic [1:0]                aksMode,
  input  drive_ctrl_t               drv,
  input  logic [CodeW-1:0]          codeOut,
  output logic [NumKeys-1:0]        activeNext,
  output logic [NumKeys-1:0]        activeReg,
  output logic [NumKeys-1:0]        outData,
  output logic [NumKeys-1:0]        outOe,
  output logic                      detData,
  output logic                      detOe
);
  logic [DeltaW-1:0]  dl [NumKeys];
  logic [NumKeys-1:0] candEn;
  logic               anyActive;

  for (genvar k = 0; k < NumKeys; k++) begin : g_unpack
    assign dl[k] = keyDelta[k*DeltaW +: DeltaW];
  end

  assign candEn = candFlags & keyEnable;

  function automatic logic shareGroup(input int a, input int b, input logic [1:0] m);
    case (aks_mode_e'(m))
      AKS_OFF:   return 1'b0;
      AKS_PAIRS: return ((a >> 1) & 1) == ((b >> 1) & 1);
      default:   return 1'b1;
    endcase
  endfunction

  // suppression: a candidate loses to any stronger (or tie-preferred) peer
  always_comb begin
    activeNext = candEn;
    for (int i = 0; i < NumKeys; i++) begin
      for (int j = 0; j < NumKeys; j++) begin
        if (j != i && candEn[j] && shareGroup(i, j, aksMode)) begin
          if (dl[j] > dl[i]) activeNext[i] = 1'b0;
          else if (dl[j] == dl[i]) begin
            if (activeReg[j] && !activeReg[i]) activeNext[i] = 1'b0;
            else if ((activeReg[j] == activeReg[i]) && (j < i)) activeNext[i] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeReg <= '0;
    else       activeReg <= activeNext;
  end

  assign anyActive = |activeReg;

  always_comb begin
    outData = '0;
    outOe   = '1;
    detData = anyActive;
    detOe   = 1'b1;
    if (drv.binMode) begin
      outData[CodeW-1:0] = codeOut;
    end else if (drv.openDrain) begin
      outOe   = activeReg;
      detData = 1'b0;
      detOe   = anyActive;
    end else if (drv.actLow) begin
      outData = ~activeReg;
      detData = ~anyActive;
    end else begin
      outData = activeReg;
    end
  end

  // R2 global suppression leaves at most one active key
  a_r2_global_single: assert property (@(posedge clk) disable iff (!rstN)
    (aksMode[1]) |=> ($countones(activeReg) <= 1));
  // R3 grouped suppression leaves at most one per group
  a_r3_group_single: assert property (@(posedge clk) disable iff (!rstN)
    (aksMode == AKS_PAIRS) |=> (($countones(activeReg & 8'h33) <= 1) &&
                               ($countones(activeReg & 8'hCC) <= 1)));
  // R4 only enabled candidates become active
  a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((activeReg & ~$past(candFlags & keyEnable)) == '0));
  // R9 open-drain lines never drive high
  always_comb begin
    if (rstN && drv.openDrain && !drv.binMode)
      a_r9_od_low: assert ((outData & outOe) == '0);
  end
endmodule

// File: rtl/tka_control.sv
module tka_control
  import tka_pkg::*;
#(
  parameter int NumKeys = 8,
  parameter int CodeW   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumKeys-1:0] activeNext,
  input  logic [NumKeys-1:0] activeReg,
  input  logic [1:0]         outFormat,
  input  logic [1:0]         aksMode,
  input  logic               fastReq,
  output drive_ctrl_t        drv,
  output logic [CodeW-1:0]   codeOut,
  output logic               fastGrant
);
  logic             holdValid;
  logic [CodeW-1:0] holdKey;
  logic [CodeW-1:0] lowIdx;

  always_comb begin
    lowIdx = '0;
    for (int k = NumKeys - 1; k >= 0; k--) begin
      if (activeNext[k]) lowIdx = CodeW'(k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdKey   <= '0;
    end else if (!(holdValid && activeNext[holdKey])) begin
      holdValid <= |activeNext;
      holdKey   <= (|activeNext) ? lowIdx : '0;
    end
  end

  assign codeOut       = holdValid ? holdKey : '0;
  assign drv.binMode   = (out_fmt_e'(outFormat) == FMT_BIN);
  assign drv.openDrain = (out_fmt_e'(outFormat) == FMT_LOW_OD);
  assign drv.actLow    = (out_fmt_e'(outFormat) == FMT_LOW_PP) || drv.openDrain;
  assign fastGrant     = fastReq && (aks_mode_e'(aksMode) == AKS_OFF);

  // R6 a held key that stays active keeps the code
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && activeNext[holdKey]) |=> (holdValid && $stable(holdKey)));
  // R8 a code is held exactly when some key is active
  a_r8_valid_match: assert property (@(posedge clk) disable iff (!rstN)
    holdValid == (|activeReg));
  // R7 held key always names an active key
  a_r7_held_active: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> activeReg[holdKey]);
endmodule

// File: rtl/touch_key_arbiter.sv
module touch_key_arbiter
  import tka_pkg::*;
#(
  parameter int NumKeys = 8,
  parameter int DeltaW  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumKeys-1:0]        candFlags,
  input  logic [NumKeys-1:0]        keyEnable,
  input  logic [NumKeys*DeltaW-1:0] keyDelta,
  input  logic [1:0]                aksMode,
  input  logic [1:0]                outFormat,
  input  logic                      fastReq,
  output logic [NumKeys-1:0]        outData,
  output logic [NumKeys-1:0]        outOe,
  output logic                      detData,
  output logic                      detOe,
  output logic                      fastGrant
);
  localparam int CodeW = $clog2(NumKeys);

  drive_ctrl_t        drv;
  logic [CodeW-1:0]   codeOut;
  logic [NumKeys-1:0] activeNext;
  logic [NumKeys-1:0] activeReg;

  tka_datapath #(.NumKeys(NumKeys), .DeltaW(DeltaW), .CodeW(CodeW)) dp_i (
    .clk(clk), .rstN(rstN), .candFlags(candFlags), .keyEnable(keyEnable),
    .keyDelta(keyDelta), .aksMode(aksMode), .drv(drv), .codeOut(codeOut),
    .activeNext(activeNext), .activeReg(activeReg), .outData(outData),
    .outOe(outOe), .detData(detData), .detOe(detOe)
  );

  tka_control #(.NumKeys(NumKeys), .CodeW(CodeW)) ctl_i (
    .clk(clk), .rstN(rstN), .activeNext(activeNext), .activeReg(activeReg),
    .outFormat(outFormat), .aksMode(aksMode), .fastReq(fastReq), .drv(drv),
    .codeOut(codeOut), .fastGrant(fastGrant)
  );
endmodule

// File: tb/touch_key_arbiter_tb_top.sv
module touch_key_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  candFlags = '0;
  logic [7:0]  keyEnable = 8'hFF;
  logic [63:0] keyDelta = '0;
  logic [1:0]  aksMode = 2'b00;
  logic [1:0]  outFormat = 2'b01;
  logic        fastReq = 1'b0;
  logic [7:0]  outData, outOe;
  logic        detData, detOe, fastGrant;

  logic [7:0]  dv [8];
  logic [7:0]  expPrev = '0;
  logic        expHv = 1'b0;
  logic [2:0]  expHk = '0;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  touch_key_arbiter dut_i (
    .clk(clk), .rstN(rstN), .candFlags(candFlags), .keyEnable(keyEnable),
    .keyDelta(keyDelta), .aksMode(aksMode), .outFormat(outFormat),
    .fastReq(fastReq), .outData(outData), .outOe(outOe), .detData(detData),
    .detOe(detOe), .fastGrant(fastGrant)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic packDeltas();
    for (int k = 0; k < 8; k++) keyDelta[k*8 +: 8] = dv[k];
  endtask

  // reference model of one clock edge, built from the requirements
  task automatic modelEdge();
    logic [7:0] ce, nxt;
    int ng, best;
    ce = candFlags & keyEnable;
    nxt = '0;
    if (aksMode == 2'b00) nxt = ce;
    else begin
      ng = (aksMode == 2'b01) ? 2 : 1;
      for (int g = 0; g < ng; g++) begin
        best = -1;
        for (int k = 0; k < 8; k++) begin
          if (ce[k] && (ng == 1 || ((k >> 1) & 1) == g)) begin
            if (best < 0) best = k;
            else if (dv[k] > dv[best]) best = k;
            else if (dv[k] == dv[best] && expPrev[k] && !expPrev[best]) best = k;
          end
        end
        if (best >= 0) nxt[best] = 1'b1;
      end
    end
    if (!(expHv && nxt[expHk])) begin
      expHv = |nxt;
      expHk = '0;
      for (int k = 7; k >= 0; k--) if (nxt[k]) expHk = 3'(k);
    end
    expPrev = nxt;
  endtask

  task automatic checkOutputs(input string tag);
    logic [7:0] eD, eO;
    logic eDd, eDo, any;
    any = |expPrev;
    eO = 8'hFF; eDo = 1'b1;
    case (outFormat)
      2'b00: begin eD = ~expPrev; eDd = ~any; end
      2'b01: begin eD = expPrev; eDd = any; end
      2'b10: begin eD = '0; eO = expPrev; eDd = 1'b0; eDo = any; end
      default: begin eD = {5'b0, expHv ? expHk : 3'b0}; eDd = any; end
    endcase
    chk({tag, " data"}, 16'(outData), 16'(eD));
    chk({tag, " oe"}, 16'(outOe), 16'(eO));
    chk({tag, " R8 detect"}, 16'({detData, detOe}), 16'({eDd, eDo}));
  endtask

  task automatic step(input string tag);
    packDeltas();
    @(posedge clk);
    modelEdge();
    #2;
    checkOutputs(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) dv[k] = '0;
    repeat (3) @(posedge clk);
    #2;
    outFormat = 2'b01; #1;
    chk("R1 reset high data", 16'({outData, detData}), 16'h0);
    outFormat = 2'b00; #1;
    chk("R1 reset low data", 16'({outData, outOe, detData, detOe}), 16'hFFFF >> 0 & 16'hFFFF);
    chk("R1 reset det", 16'({detData, detOe}), 16'h3);
    rstN = 1'b1;
    outFormat = 2'b01;

    // R11 sweep of all patterns, modes and two enable masks
    for (int m = 0; m < 4; m++) begin
      for (int em = 0; em < 2; em++) begin
        for (int p = 0; p < 256; p++) begin
          aksMode = 2'(m);
          keyEnable = em ? 8'hA5 : 8'hFF;
          candFlags = 8'(p);
          for (int k = 0; k < 8; k++) dv[k] = 8'(((p * 7 + k * 37 + m * 13) >> 1) & 15);
          case (m)
            0: step(em ? "R4 off masked" : "R4 off");
            1: step("R3 grouped");
            default: step("R2 global");
          endcase
        end
      end
    end

    // R5 tie priority
    aksMode = 2'b10; keyEnable = 8'hFF; candFlags = 8'h00;
    for (int k = 0; k < 8; k++) dv[k] = 8'd5;
    step("R5 clear");
    candFlags = 8'h48; step("R5 tie");
    chk("R5 lower index wins", 16'(outData), 16'h08);
    candFlags = 8'h4A; step("R5 tie incumbent");
    chk("R5 incumbent keeps", 16'(outData), 16'h08);

    // R6 / R7 binary hold sequence
    aksMode = 2'b00; outFormat = 2'b11; candFlags = 8'h00; step("R7 clear");
    candFlags = 8'h20; step("R6 first");
    chk("R6 first key code", 16'({outData, detData}), 16'({8'd5, 1'b1}));
    candFlags = 8'h24; step("R6 later hidden");
    chk("R6 later key hidden", 16'(outData), 16'd5);
    candFlags = 8'h64; step("R6 still hidden");
    candFlags = 8'h44; step("R7 release");
    chk("R7 lowest waiting key", 16'(outData), 16'd2);
    candFlags = 8'h00; step("R7 none");
    chk("R7 code zero no detect", 16'({outData, detData}), 16'h0);
    candFlags = 8'h01; step("R8 key0");
    chk("R8 key0 code with detect", 16'({outData, detData}), 16'h1);
    candFlags = 8'h0; step("R7 clear2");
    candFlags = 8'h90; step("R7 simultaneous");
    chk("R7 simultaneous lowest", 16'(outData), 16'd4);

    // R6 binary sweep with global and off suppression
    for (int m = 0; m < 3; m += 2) begin
      for (int s = 0; s < 300; s++) begin
        aksMode = 2'(m);
        candFlags = 8'((s * 29 + 3) & 255) & 8'((s * 53 + 11) & 255);
        for (int k = 0; k < 8; k++) dv[k] = 8'((s + k * 11) & 7);
        step("R6 binary sweep");
      end
    end

    // R9 all formats with one active set
    aksMode = 2'b00; candFlags = 8'h24;
    for (int f = 0; f < 4; f++) begin
      outFormat = 2'(f);
      step("R9 format");
    end
    outFormat = 2'b10; candFlags = 8'h00; step("R9 od idle");
    chk("R9 od idle enables", 16'({outOe, detOe}), 16'h0);

    // R10 fast grant
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        aksMode = 2'(m); fastReq = r[0];
        #1;
        chk("R10 fast grant", 16'(fastGrant), 16'(r == 1 && m == 0));
      end
    end

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    summary();
    $finish;
  end
endmodule